// File: doc/BRIEF.md
# Byte ALU with Selective Status Flags

This block is the arithmetic and logic datapath of a small 8-bit processor core. A decoder elsewhere supplies an operation code, two operand bytes and, for the flag instructions, a flag index. The block returns the result byte combinationally, along with the flag byte it would write. On every cycle in which the enable input is high, it stores that flag byte in its own 8-bit status register. The carry that feeds the with-carry operations and the rotates is taken from that stored register.

Each operation writes only its own fixed set of flags and leaves every other status bit as it was. The logic operations keep the carry and half-carry. Increment and decrement keep the carry. Nibble swap changes no flag at all. The two top bits, I and T, change only through the flag set and clear operations. Status bit positions are, from bit 0 upward: C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7.

Top module: `byte_alu_flags`

## Requirements
- R1: After reset the status register is 0x00. While `en` is low it holds its value, and `flags_nx` still shows the value that would be written.
- R2: Op 0 (add) and op 1 (add plus stored C) give the low byte of the sum. C is the carry out of bit 7, H is the carry out of bit 3, and V is the signed overflow. N and Z follow the result.
- R3: Op 2 (subtract) and op 3 (subtract with stored C as borrow) give the low byte of a - b - borrow. C is the borrow out of bit 7, H is the borrow out of bit 3, and V is the signed overflow. N and Z follow the result.
- R4: Ops 4 (AND), 5 (OR) and 6 (XOR) clear V, set N and Z from the result, and keep C and H.
- R5: Op 7 returns 0xFF minus operand a. It sets C to 1, clears V, sets N and Z from the result, and keeps H.
- R6: Op 8 returns 0x00 minus operand a. C is set exactly when a is nonzero, V exactly when a is 0x80, and H exactly when the low nibble of a is nonzero.
- R7: Op 9 returns a+1 and op 10 returns a-1. V is set only when op 9 goes 0x7F to 0x80 or op 10 goes 0x80 to 0x7F. N and Z are updated; C and H are kept.
- R8: Op 11 shifts a right and fills bit 7 with 0. Op 12 shifts a right and keeps bit 7. For both, C takes the old bit 0, N and Z follow the result, and V equals N XOR C.
- R9: Op 13 rotates a left through carry and op 14 rotates it right through carry. The stored C enters the vacated end, and the bit that leaves goes to C. V equals N XOR C.
- R10: Op 15 exchanges the two nibbles of a and changes no flag.
- R11: Op 16 sets and op 17 clears the single status bit indexed by `fsel`. All other bits are kept, and the result is a unchanged.
- R12: Whenever ops 0 to 14 write N or V, S becomes N XOR V. Ops other than 16 and 17 never change I or T.
- R13: Op codes 18 to 31 return a unchanged and leave every flag as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Commit `flags_nx` to the status register at the clock edge |
| op | input | 5 | Operation code |
| opa | input | 8 | First operand, the destination value |
| opb | input | 8 | Second operand |
| fsel | input | 3 | Status bit index for ops 16 and 17 |
| res | output | 8 | Result byte (combinational) |
| flags_nx | output | 8 | Flag byte the current operation would write |
| sreg | output | 8 | Stored status register |

## Verification
Boundary operands around 0x7F/0x80, 0x00/0xFF and the 0x0F/0x10 nibble edge each expose one flag. They separate signed overflow from unsigned carry, carry out of bit 3 from carry out of bit 7, and the zero result from the negative one. The with-carry adds and subtracts and the rotates run with the stored carry both clear and set, which shows whether the carry is actually read. A long random sweep over all 32 op codes, with the carry left to drift, is compared against an integer-arithmetic model. Sequences that first set I and T and then run data operations show that untouched bits survive.

// File: rtl/byte_alu_flags.sv
module byte_alu_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [4:0] op,
  input  logic [7:0] opa,
  input  logic [7:0] opb,
  input  logic [2:0] fsel,
  output logic [7:0] res,
  output logic [7:0] flags_nx,
  output logic [7:0] sreg
);
  localparam int FC = 0, FZ = 1, FN = 2, FV = 3, FS = 4, FH = 5, FT = 6, FI = 7;

  localparam logic [4:0] OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3;
  localparam logic [4:0] OP_AND = 5'd4,  OP_OR  = 5'd5,  OP_XOR = 5'd6,  OP_COM = 5'd7;
  localparam logic [4:0] OP_NEG = 5'd8,  OP_INC = 5'd9,  OP_DEC = 5'd10, OP_LSR = 5'd11;
  localparam logic [4:0] OP_ASR = 5'd12, OP_ROL = 5'd13, OP_ROR = 5'd14, OP_SWP = 5'd15;
  localparam logic [4:0] OP_FST = 5'd16, OP_FCL = 5'd17;

  logic       sub_m, cin, ci;
  logic [7:0] ax, ay, yy;
  logic [8:0] sum9;
  logic       c_ar, h_ar, v_ar;

  assign sub_m = (op == OP_SUB) || (op == OP_SBC) || (op == OP_NEG);
  assign ax    = (op == OP_NEG) ? 8'h00 : opa;
  assign ay    = (op == OP_NEG) ? opa : opb;
  assign cin   = ((op == OP_ADC) || (op == OP_SBC)) && sreg[FC];
  assign yy    = ay ^ {8{sub_m}};
  assign ci    = cin ^ sub_m;
  assign sum9  = {1'b0, ax} + {1'b0, yy} + {8'b0, ci};
  assign c_ar  = sum9[8] ^ sub_m;
  assign h_ar  = (ax[4] ^ yy[4] ^ sum9[4]) ^ sub_m;
  assign v_ar  = (ax[7] == yy[7]) && (sum9[7] != ax[7]);

  logic [7:0] r, f;
  logic       wr_nz, wr_sh;

  always_comb begin
    r     = opa;
    f     = sreg;
    wr_nz = 1'b0;
    wr_sh = 1'b0;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
        r = sum9[7:0]; f[FC] = c_ar; f[FH] = h_ar; f[FV] = v_ar; wr_nz = 1'b1;
      end
      OP_AND: begin r = opa & opb; f[FV] = 1'b0; wr_nz = 1'b1; end
      OP_OR:  begin r = opa | opb; f[FV] = 1'b0; wr_nz = 1'b1; end
      OP_XOR: begin r = opa ^ opb; f[FV] = 1'b0; wr_nz = 1'b1; end
      OP_COM: begin r = ~opa; f[FC] = 1'b1; f[FV] = 1'b0; wr_nz = 1'b1; end
      OP_INC: begin r = opa + 8'd1; f[FV] = (opa == 8'h7F); wr_nz = 1'b1; end
      OP_DEC: begin r = opa - 8'd1; f[FV] = (opa == 8'h80); wr_nz = 1'b1; end
      OP_LSR: begin r = {1'b0, opa[7:1]};     f[FC] = opa[0]; wr_sh = 1'b1; end
      OP_ASR: begin r = {opa[7], opa[7:1]};   f[FC] = opa[0]; wr_sh = 1'b1; end
      OP_ROL: begin r = {opa[6:0], sreg[FC]}; f[FC] = opa[7]; wr_sh = 1'b1; end
      OP_ROR: begin r = {sreg[FC], opa[7:1]}; f[FC] = opa[0]; wr_sh = 1'b1; end
      OP_SWP: r = {opa[3:0], opa[7:4]};
      OP_FST: f[fsel] = 1'b1;
      OP_FCL: f[fsel] = 1'b0;
      default: ;
    endcase
    if (wr_nz || wr_sh) begin
      f[FN] = r[7];
      f[FZ] = (r == 8'h00);
      if (wr_sh) f[FV] = r[7] ^ f[FC];
      f[FS] = f[FN] ^ f[FV];
    end
  end

  assign res      = r;
  assign flags_nx = f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sreg <= 8'h00;
    else if (en) sreg <= f;
  end

  assert_hold_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> sreg == $past(sreg));

  assert_logic_keeps_ch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en && (op == OP_AND || op == OP_OR || op == OP_XOR) |=>
      !sreg[FV] && sreg[FC] == $past(sreg[FC]) && sreg[FH] == $past(sreg[FH]));

  assert_com_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    en && op == OP_COM |=> sreg[FC] && !sreg[FV]);

  assert_incdec_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    en && (op == OP_INC || op == OP_DEC) |=> sreg[FC] == $past(sreg[FC]));

  assert_swap_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    en && op == OP_SWP |=> sreg == $past(sreg));

  assert_sign_rule_R12: assert property (@(posedge clk) disable iff (!rst_n)
    en && op <= OP_ROR && op != OP_SWP |=> sreg[FS] == (sreg[FN] ^ sreg[FV]));

  assert_it_kept_R12: assert property (@(posedge clk) disable iff (!rst_n)
    en && op != OP_FST && op != OP_FCL |=> sreg[FI] == $past(sreg[FI]) && sreg[FT] == $past(sreg[FT]));

  assert_unused_op_R13: assert property (@(posedge clk) disable iff (!rst_n)
    en && op > OP_FCL |=> sreg == $past(sreg));
endmodule

// File: tb/byte_alu_flags_test.sv
module byte_alu_flags_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [4:0] op = 5'd0;
  logic [7:0] opa = 8'h00, opb = 8'h00;
  logic [2:0] fsel = 3'd0;
  logic [7:0] res, flags_nx, sreg;

  byte_alu_flags uut (.clk(clk), .rst_n(rst_n), .en(en), .op(op), .opa(opa), .opb(opb),
                      .fsel(fsel), .res(res), .flags_nx(flags_nx), .sreg(sreg));

  always #5 clk = ~clk;

  typedef struct {
    logic [7:0] r;
    logic [7:0] f;
    logic [7:0] s_after;
    logic [4:0] op;
    logic       en;
  } item_t;

  item_t      q[$];
  int         checks = 0, errors = 0;
  logic [7:0] model_sreg = 8'h00;
  bit         done = 0;

  function automatic string tag_of(logic [4:0] o, logic e);
    if (!e) return "R1";
    case (o)
      5'd0, 5'd1:        return "R2";
      5'd2, 5'd3:        return "R3";
      5'd4, 5'd5, 5'd6:  return "R4";
      5'd7:              return "R5";
      5'd8:              return "R6";
      5'd9, 5'd10:       return "R7";
      5'd11, 5'd12:      return "R8";
      5'd13, 5'd14:      return "R9";
      5'd15:             return "R10";
      5'd16, 5'd17:      return "R11";
      default:           return "R13";
    endcase
  endfunction

  function automatic int sval(logic [7:0] v);
    int t;
    t = v;
    if (t > 127) t = t - 256;
    return t;
  endfunction

  function automatic logic [15:0] ref_op(logic [4:0] o, logic [7:0] a, logic [7:0] b,
                                         logic [2:0] fs, logic [7:0] sr);
    int x, y, k, t, st;
    logic [7:0] r, f;
    bit nz, sh;
    f = sr; r = a; nz = 0; sh = 0;
    case (o)
      5'd0, 5'd1: begin
        k = (o == 5'd1) ? int'(sr[0]) : 0;
        t = int'(a) + int'(b) + k; r = t[7:0];
        f[0] = t > 255;
        f[5] = (int'(a) % 16 + int'(b) % 16 + k) > 15;
        st = sval(a) + sval(b) + k; f[3] = (st > 127) || (st < -128); nz = 1;
      end
      5'd2, 5'd3, 5'd8: begin
        x = (o == 5'd8) ? 0 : int'(a);
        y = (o == 5'd8) ? int'(a) : int'(b);
        k = (o == 5'd3) ? int'(sr[0]) : 0;
        t = x - y - k; r = t[7:0];
        f[0] = t < 0;
        f[5] = (x % 16 - y % 16 - k) < 0;
        st = sval(x[7:0]) - sval(y[7:0]) - k; f[3] = (st > 127) || (st < -128); nz = 1;
      end
      5'd4: begin r = a & b; f[3] = 0; nz = 1; end
      5'd5: begin r = a | b; f[3] = 0; nz = 1; end
      5'd6: begin r = a ^ b; f[3] = 0; nz = 1; end
      5'd7: begin t = 255 - int'(a); r = t[7:0]; f[0] = 1; f[3] = 0; nz = 1; end
      5'd9:  begin t = int'(a) + 1; r = t[7:0]; f[3] = (a == 8'd127); nz = 1; end
      5'd10: begin t = int'(a) - 1; r = t[7:0]; f[3] = (a == 8'd128); nz = 1; end
      5'd11: begin r = a >> 1; f[0] = a[0]; sh = 1; end
      5'd12: begin r = {a[7], a[7:1]}; f[0] = a[0]; sh = 1; end
      5'd13: begin r = {a[6:0], sr[0]}; f[0] = a[7]; sh = 1; end
      5'd14: begin r = {sr[0], a[7:1]}; f[0] = a[0]; sh = 1; end
      5'd15: r = {a[3:0], a[7:4]};
      5'd16: f[fs] = 1;
      5'd17: f[fs] = 0;
      default: ;
    endcase
    if (nz || sh) begin
      f[2] = r[7]; f[1] = (r == 0);
      if (sh) f[3] = f[2] ^ f[0];
      f[4] = f[2] ^ f[3];
    end
    return {r, f};
  endfunction

  task automatic drive(logic [4:0] o, logic [7:0] a, logic [7:0] b, logic [2:0] fs, logic e);
    logic [15:0] x;
    item_t it;
    @(negedge clk);
    op = o; opa = a; opb = b; fsel = fs; en = e;
    x = ref_op(o, a, b, fs, model_sreg);
    it.r = x[15:8]; it.f = x[7:0]; it.op = o; it.en = e;
    it.s_after = e ? x[7:0] : model_sreg;
    q.push_back(it);
    model_sreg = it.s_after;
  endtask

  initial begin : monitor
    item_t it;
    string tg;
    forever begin
      @(negedge clk);
      #3;
      if (q.size() > 0) begin
        it = q.pop_front();
        tg = tag_of(it.op, it.en);
        checks++;
        if (res !== it.r) begin
          errors++;
          $display("FAIL %s op=%0d res actual=%h expected=%h", tg, it.op, res, it.r);
        end
        checks++;
        if (flags_nx !== it.f) begin
          errors++;
          $display("FAIL %s op=%0d flags_nx actual=%b expected=%b", tg, it.op, flags_nx, it.f);
        end
        @(posedge clk);
        #1;
        checks++;
        if (sreg !== it.s_after) begin
          errors++;
          $display("FAIL %s op=%0d sreg actual=%b expected=%b", tg, it.op, sreg, it.s_after);
        end
        if (it.en && it.op <= 5'd14 && it.op != 5'd15) begin
          checks++; // R12: S equals N xor V after an N/V writer
          if (sreg[4] !== (sreg[2] ^ sreg[3])) begin
            errors++;
            $display("FAIL R12 S actual=%b expected=%b", sreg[4], sreg[2] ^ sreg[3]);
          end
        end
      end
    end
  end

  initial begin : watchdog
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    checks++;
    if (sreg !== 8'h00) begin
      errors++;
      $display("FAIL R1 reset sreg actual=%h expected=00", sreg);
    end
    rst_n = 1'b1;
    drive(5'd16, 8'h5A, 8'h00, 3'd7, 1'b1);   // R11 set I
    drive(5'd16, 8'h5A, 8'h00, 3'd6, 1'b1);   // R11 set T
    drive(5'd0,  8'h7F, 8'h01, 3'd0, 1'b1);   // R2 overflow + half carry
    drive(5'd0,  8'hFF, 8'h01, 3'd0, 1'b1);   // R2 carry, zero
    drive(5'd1,  8'h10, 8'h20, 3'd0, 1'b1);   // R2 adc with C=1
    drive(5'd1,  8'h10, 8'h20, 3'd0, 1'b1);   // R2 adc with C=0
    drive(5'd0,  8'h55, 8'h11, 3'd0, 1'b0);   // R1 en low holds
    drive(5'd2,  8'h80, 8'h01, 3'd0, 1'b1);   // R3 signed overflow
    drive(5'd2,  8'h10, 8'h01, 3'd0, 1'b1);   // R3 half borrow
    drive(5'd2,  8'h00, 8'h01, 3'd0, 1'b1);   // R3 borrow sets C
    drive(5'd3,  8'h05, 8'h05, 3'd0, 1'b1);   // R3 sbc with C=1
    drive(5'd4,  8'hF0, 8'h0F, 3'd0, 1'b1);   // R4 zero, C kept
    drive(5'd6,  8'hF0, 8'h0F, 3'd0, 1'b1);   // R4
    drive(5'd7,  8'hFF, 8'h00, 3'd0, 1'b1);   // R5 zero result, C=1
    drive(5'd8,  8'h80, 8'h00, 3'd0, 1'b1);   // R6 V
    drive(5'd8,  8'h00, 8'h00, 3'd0, 1'b1);   // R6 C clear
    drive(5'd8,  8'h01, 8'h00, 3'd0, 1'b1);   // R6
    drive(5'd9,  8'h7F, 8'h00, 3'd0, 1'b1);   // R7 inc overflow
    drive(5'd10, 8'h80, 8'h00, 3'd0, 1'b1);   // R7 dec overflow
    drive(5'd9,  8'hFF, 8'h00, 3'd0, 1'b1);   // R7 wrap, C kept
    drive(5'd12, 8'h81, 8'h00, 3'd0, 1'b1);   // R8 asr
    drive(5'd11, 8'h01, 8'h00, 3'd0, 1'b1);   // R8 lsr to zero
    drive(5'd13, 8'h80, 8'h00, 3'd0, 1'b1);   // R9 rol C in/out
    drive(5'd13, 8'h00, 8'h00, 3'd0, 1'b1);   // R9 rol with C=1
    drive(5'd14, 8'h01, 8'h00, 3'd0, 1'b1);   // R9 ror
    drive(5'd15, 8'hA5, 8'h00, 3'd0, 1'b1);   // R10 swap
    drive(5'd17, 8'h3C, 8'h00, 3'd7, 1'b1);   // R11 clear I
    drive(5'd20, 8'h99, 8'h11, 3'd0, 1'b1);   // R13 unused op
    drive(5'd31, 8'h00, 8'hFF, 3'd0, 1'b1);   // R13 unused op
    for (int i = 0; i < 600; i++) begin
      drive(5'($urandom_range(0, 31)), 8'($urandom), 8'($urandom),
            3'($urandom_range(0, 7)), ($urandom_range(0, 7) != 0));
    end
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule